// File: doc/BRIEF.md
# Packed-BCD Decimal Adjust Unit

This block repairs an 8-bit accumulator after a plain binary addition or subtraction of two packed-BCD bytes, so that the result is once more two valid decimal digits. It reads the accumulator together with the flag byte the arithmetic step left behind. The subtract, half-carry and carry bits choose and steer the correction. It returns the adjusted accumulator and a freshly built flag byte.

Each strobe on `in_valid` starts one adjustment. The result is registered and comes out one clock later with a single-cycle `out_valid` pulse. The outputs keep their last value until the next strobe arrives. The flag byte uses a fixed layout: bit 0 carry, bit 1 subtract, bit 2 parity, bit 4 half-carry, bit 6 zero and bit 7 sign. Bits 3 and 5 are unused.

Top module: `bcd_fixup`

## Requirements
- R1: With subtract (bit 1) clear, when the low nibble of A is 10 or more, 6 is added and half-carry (bit 4) is set. Otherwise, when input half-carry is set, 6 is added and half-carry stays clear. Otherwise the low nibble is untouched and half-carry is clear.
- R2: With subtract clear, after the R1 step, when the intermediate value is 0xA0 or more or input carry (bit 0) is set, 0x60 is added and carry is set. Otherwise carry is clear.
- R3: With subtract set, the high check is made on the unmodified A. When A is above 0x99 or input carry is set, 0x60 is subtracted and carry is set.
- R4: With subtract set, after the R3 step, when the low nibble of A is above 9 or input half-carry is set, 6 is subtracted. Half-carry is set only in that case and only when the low nibble of A was below 6.
- R5: With subtract set, when the R4 subtraction leaves a negative intermediate value and input half-carry was clear, carry is set. The result byte is the intermediate value taken modulo 256.
- R6: The output subtract bit equals the input subtract bit. Output bits 3 and 5 are always 0. Input bits 2, 3, 5, 6 and 7 have no effect on any output.
- R7: Sign (bit 7) equals bit 7 of the result. Zero (bit 6) is set when the result is 0x00. Parity (bit 2) is set when the result has an even number of one bits.
- R8: The result appears on the clock edge after an `in_valid` strobe, with `out_valid` high for exactly that cycle. Without a strobe, `acc_out` and `flags_out` hold.
- R9: While reset is active, and until the first strobe, `out_valid`, `acc_out` and `flags_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Start one adjustment |
| acc_in | input | 8 | Accumulator after the binary operation |
| flags_in | input | 8 | Flag byte after the binary operation |
| out_valid | output | 1 | Result valid pulse |
| acc_out | output | 8 | Adjusted accumulator |
| flags_out | output | 8 | New flag byte |

## Verification
The bench sweeps every accumulator value against all eight combinations of subtract, half-carry and carry, so the edges of each comparison are covered. These edges are a low nibble of 9 against 10, an intermediate of 0x9F against 0xA0, and A of 0x99 against 0x9A. A design that used the wrong comparison operator, or ran the subtract corrections in the add order, would give a wrong byte or a wrong carry at exactly these values. The half-carry rule on the subtract path, which depends on the low nibble being below 6, is hit at 0x05/0x06 with half-carry set, where a design that copied the add rule would invert the flag. Random filler in the unused input flag bits, together with idle gaps between strobes, would expose a design that leaked those bits into the result or failed to hold its output.

// File: rtl/bcd_fixup.sv
module bcd_fixup #(
  parameter int C_BIT = 0,
  parameter int N_BIT = 1,
  parameter int P_BIT = 2,
  parameter int H_BIT = 4,
  parameter int Z_BIT = 6,
  parameter int S_BIT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] acc_in,
  input  logic [7:0] flags_in,
  output logic       out_valid,
  output logic [7:0] acc_out,
  output logic [7:0] flags_out
);

  logic              sub_in, hc_in, cy_in;
  logic [3:0]        lo;
  logic signed [9:0] a_s;

  assign sub_in = flags_in[N_BIT];
  assign hc_in  = flags_in[H_BIT];
  assign cy_in  = flags_in[C_BIT];
  assign lo     = acc_in[3:0];
  assign a_s    = $signed({2'b00, acc_in});

  logic              add_lo_fix, add_hi_fix;
  logic signed [9:0] add_mid, add_res;

  assign add_lo_fix = (lo >= 4'd10) || hc_in;
  assign add_mid    = a_s + (add_lo_fix ? 10'sd6 : 10'sd0);
  assign add_hi_fix = (add_mid >= 10'sd160) || cy_in;
  assign add_res    = add_mid + (add_hi_fix ? 10'sd96 : 10'sd0);

  logic              sub_hi_fix, sub_lo_fix;
  logic signed [9:0] sub_mid, sub_res;

  assign sub_hi_fix = (acc_in > 8'h99) || cy_in;
  assign sub_mid    = a_s - (sub_hi_fix ? 10'sd96 : 10'sd0);
  assign sub_lo_fix = (lo > 4'd9) || hc_in;
  assign sub_res    = sub_mid - (sub_lo_fix ? 10'sd6 : 10'sd0);

  logic [7:0] res;
  logic       cy_new, hc_new;

  always_comb begin
    if (!sub_in) begin
      res    = add_res[7:0];
      cy_new = add_hi_fix;
      hc_new = lo >= 4'd10;
    end else begin
      res    = sub_res[7:0];
      cy_new = sub_hi_fix || (sub_lo_fix && (sub_res < 10'sd0) && !hc_in);
      hc_new = sub_lo_fix && (lo < 4'd6);
    end
  end

  logic [7:0] fl_new;

  always_comb begin
    fl_new        = 8'h00;
    fl_new[C_BIT] = cy_new;
    fl_new[N_BIT] = sub_in;
    fl_new[H_BIT] = hc_new;
    fl_new[P_BIT] = ~^res;
    fl_new[Z_BIT] = res == 8'h00;
    fl_new[S_BIT] = res[7];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= 8'h00;
      flags_out <= 8'h00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out   <= res;
        flags_out <= fl_new;
      end
    end
  end

  // R6
  sub_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> flags_out[N_BIT] == $past(flags_in[N_BIT]));

  // R6
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_out[3] == 1'b0 && flags_out[5] == 1'b0);

  // R7
  szp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[S_BIT] == acc_out[7]) &&
                  (flags_out[Z_BIT] == (acc_out == 8'h00)) &&
                  (flags_out[P_BIT] == ~^acc_out));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(acc_out) && $stable(flags_out));

  // R1
  add_hc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flags_in[N_BIT] && acc_in[3:0] < 4'd10) |=> !flags_out[H_BIT]);

endmodule

// File: tb/sim_bcd_fixup.sv
module sim_bcd_fixup;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] flags_in = 8'h00;
  logic       out_valid;
  logic [7:0] acc_out;
  logic [7:0] flags_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_fixup u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .acc_in(acc_in), .flags_in(flags_in),
    .out_valid(out_valid), .acc_out(acc_out), .flags_out(flags_out)
  );

  // expected result: {flags, acc}
  function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] f);
    int d, lo;
    bit n, h, c, ho, co;
    logic [7:0] r, fo;
    n = f[1]; h = f[4]; c = f[0];
    d = a; lo = a % 16; ho = 0; co = 0;
    if (!n) begin
      if (lo >= 10) begin d += 6; ho = 1; end
      else if (h) d += 6;
      if (d >= 160 || c) begin d += 96; co = 1; end
    end else begin
      if (a > 153 || c) begin d -= 96; co = 1; end
      if (lo > 9 || h) begin
        if (lo < 6) ho = 1;
        d -= 6;
        if (d < 0 && !h) co = 1;
      end
    end
    r = d[7:0];
    fo = 8'h00;
    fo[0] = co; fo[1] = n; fo[4] = ho;
    fo[2] = ($countones(r) % 2) == 0;
    fo[6] = r == 8'h00;
    fo[7] = r[7];
    return {fo, r};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] f, input int gap);
    logic [15:0] e;
    logic [7:0] msk;
    e = model(a, f);
    msk = 8'h11;
    @(negedge clk);
    in_valid = 1'b1; acc_in = a; flags_in = f;
    @(negedge clk);
    in_valid = 1'b0; acc_in = $urandom; flags_in = $urandom;
    check("R8 valid", {31'd0, out_valid}, 32'd1);
    if (!f[1]) begin
      check("R1 R2 acc", {24'd0, acc_out}, {24'd0, e[7:0]});
      check("R1 R2 h/c", {24'd0, flags_out & msk}, {24'd0, e[15:8] & msk});
    end else begin
      check("R3 R4 R5 acc", {24'd0, acc_out}, {24'd0, e[7:0]});
      check("R3 R4 R5 h/c", {24'd0, flags_out & msk}, {24'd0, e[15:8] & msk});
    end
    check("R6 n/unused", {24'd0, flags_out & 8'h2A}, {24'd0, e[15:8] & 8'h2A});
    check("R7 szp", {24'd0, flags_out & 8'hC4}, {24'd0, e[15:8] & 8'hC4});
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      acc_in = $urandom; flags_in = $urandom;
      check("R8 hold", {15'd0, out_valid, flags_out, acc_out}, {16'd0, e});
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0bcd));
    repeat (3) @(negedge clk);
    check("R9 reset", {15'd0, out_valid, flags_out, acc_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle", {15'd0, out_valid, flags_out, acc_out}, 32'd0);
    // directed corners
    apply(8'h9A, 8'h00, 1);
    check("R2 0x9A add", {24'd0, acc_out}, 32'h00);
    apply(8'h0A, 8'h03, 1);
    check("R5 borrow", {24'd0, acc_out, flags_out & 8'h11}, {16'd0, 8'hA4, 8'h01});
    apply(8'h05, 8'h12, 0);
    check("R4 hc below 6", {31'd0, flags_out[4]}, 32'd1);
    apply(8'h06, 8'h12, 0);
    check("R4 hc at 6", {31'd0, flags_out[4]}, 32'd0);
    apply(8'h9A, 8'h02, 0);
    check("R3 above 99", {24'd0, acc_out}, 32'h34);
    // exhaustive sweep with random filler in ignored bits
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] f;
        f = $urandom & 8'hEC;
        f[1] = k[0]; f[4] = k[1]; f[0] = k[2];
        apply(a[7:0], f, $urandom_range(0, 2) == 0 ? 1 : 0);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule